// File: doc/BRIEF.md
# Countdown and watchdog timer

This block is a programmable down-counter that advances on one of several slow tick strobes. An external prescaler produces those strobes; they are single-cycle enables in the system clock domain. In repeat mode the counter counts down from a programmed start value. At the end of each period it raises a period flag and reloads itself. In guard mode the counter runs once. On expiry it raises a guard flag and stays at zero until software writes a new start value.

Both flags feed a single interrupt output. The guard flag drives it as a level. The period flag drives it either as a level or as a short pulse. The pulse width follows the selected source, and the pulse can be cut short by clearing the flag or by dropping the enable. Software can read the current count at any time. Reading the status register clears the guard flag.

Top module: `prog_tick_timer`

## Requirements
- R1: `modeSel` = 2'b01 selects repeat mode and 2'b10 selects guard mode. With 2'b00 or 2'b11 the count does not change on any tick.
- R2: `srcSel` chooses the tick that advances the count: 3'b000 uses `tick4k`, 3'b001 uses `tick64`, 3'b010 uses `tick1`, 3'b011 uses `tickMin`, and 3'b100, 3'b110 and 3'b111 use `tickHour`. With 3'b101 no tick advances the count. A tick on any input that is not selected has no effect.
- R3: In repeat mode, a selected tick with `count` above 1 lowers `count` by one. A selected tick with `count` equal to 1 sets `cdFlag` and reloads the last written start value.
- R4: A `reloadWr` strobe loads `reloadVal` into `count` at the next clock edge, whether or not the timer is running. `count` always shows the live value, not the start value.
- R5: In guard mode, a selected tick with `count` equal to 1 sets `wdFlag` and leaves `count` at 0, where it stays. `statusRd` clears `wdFlag`.
- R6: While `count` is 0 the timer is stopped: ticks neither change it nor set any flag.
- R7: With `pulseMode` = 0, `irq` is high whenever (`cdIrqEn` and `cdFlag`) or (`wdIrqEn` and `wdFlag`).
- R8: With `pulseMode` = 1, each repeat expiry starts a pulse that drives `irq` (given `cdIrqEn`). The pulse ends at the next `tick4k` when `srcSel` = 3'b000, and at the next `tick64` for every other source. `cdFlag` itself stays set after the pulse ends.
- R9: A `cdFlagClr` strobe, or `cdIrqEn` going low, ends a running pulse at once. The pulse does not resume when the enable returns.
- R10: `cdFlagClr` clears `cdFlag`. If an expiry occurs in the same cycle, the flag is set instead.
- R11: After reset `count` is 0, both flags are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low reset, synchronous |
| tick4k | input | 1 | 4096 Hz tick strobe |
| tick64 | input | 1 | 64 Hz tick strobe |
| tick1 | input | 1 | 1 Hz tick strobe |
| tickMin | input | 1 | once-per-minute tick strobe |
| tickHour | input | 1 | once-per-hour tick strobe |
| modeSel | input | 2 | timer mode |
| srcSel | input | 3 | tick source select |
| reloadVal | input | CNT_W | start value n |
| reloadWr | input | 1 | write strobe for n |
| cdIrqEn | input | 1 | period interrupt enable |
| wdIrqEn | input | 1 | guard interrupt enable |
| pulseMode | input | 1 | 1 = pulsed period interrupt |
| cdFlagClr | input | 1 | clear strobe for the period flag |
| statusRd | input | 1 | status read strobe, clears the guard flag |
| count | output | CNT_W | live count |
| cdFlag | output | 1 | period flag |
| wdFlag | output | 1 | guard flag |
| irq | output | 1 | interrupt output |

## Verification
The assertions assume that every strobe input, ticks included, is high for a single clock cycle at a time. They also assume that `modeSel` and `srcSel` are steady around an expiry. The stimulus respects this by raising each strobe at a falling edge and dropping it at the next one, and by changing mode and source fields only while no tick is active. Only one tick input is driven in any cycle, except where a test deliberately drives an unselected tick. Flag-clear strobes are placed both apart from expiries and in the same cycle as one.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_REP  = 2'b01,
    TM_WDG  = 2'b10,
    TM_OFF2 = 2'b11
  } tmrMode_e;

  // strobes from control to datapath; at most one is acted on per cycle
  typedef struct packed {
    logic load;
    logic reload;
    logic dec;
  } tmrStrobe_t;
endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] nIn,
  output logic [CNT_W-1:0] count,
  output logic             isZero,
  output logic             atOne
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] nReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nReg  <= ZERO;
      count <= ZERO;
    end else begin
      if (stb.load) nReg <= nIn;
      if (stb.load)        count <= nIn;
      else if (stb.reload) count <= nReg;
      else if (stb.dec)    count <= count - ONE;
    end
  end

  assign isZero = (count == ZERO);
  assign atOne  = (count == ONE);

  // R3: a decrement strobe lowers the count by exactly one
  p_dec_by_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec && !stb.load |=> count == $past(count) - ONE);

  // R4: a write lands in the count on the next edge
  p_load_now_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> count == $past(nIn));
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick4k,
  input  logic       tick64,
  input  logic       tick1,
  input  logic       tickMin,
  input  logic       tickHour,
  input  logic [1:0] modeSel,
  input  logic [2:0] srcSel,
  input  logic       reloadWr,
  input  logic       cdIrqEn,
  input  logic       wdIrqEn,
  input  logic       pulseMode,
  input  logic       cdFlagClr,
  input  logic       statusRd,
  input  logic       isZero,
  input  logic       atOne,
  output tmrStrobe_t stb,
  output logic       cdFlag,
  output logic       wdFlag,
  output logic       irq
);
  tmrMode_e mode;
  logic srcTick, widthTick, running, expire, cdSet, wdSet, pulseOn;

  assign mode = tmrMode_e'(modeSel);

  always_comb begin
    unique case (srcSel)
      3'b000:                 srcTick = tick4k;
      3'b001:                 srcTick = tick64;
      3'b010:                 srcTick = tick1;
      3'b011:                 srcTick = tickMin;
      3'b100, 3'b110, 3'b111: srcTick = tickHour;
      default:                srcTick = 1'b0;
    endcase
  end

  assign widthTick = (srcSel == 3'b000) ? tick4k : tick64;
  assign running   = ((mode == TM_REP) || (mode == TM_WDG)) && !isZero;
  assign expire    = running && srcTick && atOne && !reloadWr;
  assign cdSet     = expire && (mode == TM_REP);
  assign wdSet     = expire && (mode == TM_WDG);

  always_comb begin
    stb.load   = reloadWr;
    stb.reload = cdSet;
    stb.dec    = running && srcTick && !reloadWr && !cdSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cdFlag  <= 1'b0;
      wdFlag  <= 1'b0;
      pulseOn <= 1'b0;
    end else begin
      if (cdSet)          cdFlag <= 1'b1;
      else if (cdFlagClr) cdFlag <= 1'b0;
      if (wdSet)          wdFlag <= 1'b1;
      else if (statusRd)  wdFlag <= 1'b0;
      if (cdSet && pulseMode) pulseOn <= 1'b1;
      else if (cdFlagClr || !cdIrqEn || !pulseMode || widthTick) pulseOn <= 1'b0;
    end
  end

  assign irq = (cdIrqEn && (pulseMode ? pulseOn : cdFlag)) || (wdIrqEn && wdFlag);

  // R5: guard expiry leaves the counter stopped at zero
  p_wdg_stops_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdSet |=> isZero && wdFlag);

  // R5: a status read with no new expiry leaves the guard flag clear
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !wdSet |=> !wdFlag);

  // R6: a stopped counter never raises a flag
  p_zero_no_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    isZero |-> !cdSet && !wdSet);

  // R3: a repeat expiry reloads a nonzero value and raises the flag
  p_rep_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    cdSet |=> cdFlag && !isZero);

  // R9: clearing the flag ends the pulse on the next edge
  p_clear_ends_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    cdFlagClr && !cdSet |=> !pulseOn);

  // R7: level mode reflects the period flag
  p_level_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pulseMode && cdIrqEn && cdFlag |-> irq);
endmodule

// File: rtl/prog_tick_timer.sv
module prog_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick4k,
  input  logic             tick64,
  input  logic             tick1,
  input  logic             tickMin,
  input  logic             tickHour,
  input  logic [1:0]       modeSel,
  input  logic [2:0]       srcSel,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             reloadWr,
  input  logic             cdIrqEn,
  input  logic             wdIrqEn,
  input  logic             pulseMode,
  input  logic             cdFlagClr,
  input  logic             statusRd,
  output logic [CNT_W-1:0] count,
  output logic             cdFlag,
  output logic             wdFlag,
  output logic             irq
);
  tmrStrobe_t stb;
  logic isZero, atOne;

  tick_timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .tick4k(tick4k), .tick64(tick64), .tick1(tick1),
    .tickMin(tickMin), .tickHour(tickHour),
    .modeSel(modeSel), .srcSel(srcSel), .reloadWr(reloadWr),
    .cdIrqEn(cdIrqEn), .wdIrqEn(wdIrqEn), .pulseMode(pulseMode),
    .cdFlagClr(cdFlagClr), .statusRd(statusRd),
    .isZero(isZero), .atOne(atOne),
    .stb(stb), .cdFlag(cdFlag), .wdFlag(wdFlag), .irq(irq)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .nIn(reloadVal),
    .count(count), .isZero(isZero), .atOne(atOne)
  );
endmodule

// File: tb/prog_tick_timer_tb_top.sv
`timescale 1ns/1ps
module prog_tick_timer_tb_top;
  localparam int CNT_W = 8;
  localparam logic [7:0] T4K = 8'h01, T64 = 8'h02, T1 = 8'h04, TMIN = 8'h08,
                         THR = 8'h10, WR = 8'h20, CLR = 8'h40, RD = 8'h80;

  logic clk = 1'b0, rstN = 1'b0;
  logic tick4k = 0, tick64 = 0, tick1 = 0, tickMin = 0, tickHour = 0;
  logic [1:0] modeSel = 2'b00;
  logic [2:0] srcSel = 3'b010;
  logic [CNT_W-1:0] reloadVal = '0;
  logic reloadWr = 0, cdIrqEn = 0, wdIrqEn = 0, pulseMode = 0, cdFlagClr = 0, statusRd = 0;
  logic [CNT_W-1:0] count;
  logic cdFlag, wdFlag, irq;

  typedef struct {
    string tag;
    logic [CNT_W-1:0] cnt;
    logic cd, wd, ir;
  } expItem_t;
  expItem_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prog_tick_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .tick4k(tick4k), .tick64(tick64), .tick1(tick1),
    .tickMin(tickMin), .tickHour(tickHour), .modeSel(modeSel), .srcSel(srcSel),
    .reloadVal(reloadVal), .reloadWr(reloadWr), .cdIrqEn(cdIrqEn), .wdIrqEn(wdIrqEn),
    .pulseMode(pulseMode), .cdFlagClr(cdFlagClr), .statusRd(statusRd),
    .count(count), .cdFlag(cdFlag), .wdFlag(wdFlag), .irq(irq)
  );

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      total++;
      if (count !== e.cnt || cdFlag !== e.cd || wdFlag !== e.wd || irq !== e.ir) begin
        bad++;
        $display("FAIL %s: got count=%0d cd=%b wd=%b irq=%b, expected count=%0d cd=%b wd=%b irq=%b",
                 e.tag, count, cdFlag, wdFlag, irq, e.cnt, e.cd, e.wd, e.ir);
      end
    end
  end

  task automatic chk(input string tag, input int c, input logic cd, input logic wd, input logic ir);
    expItem_t e;
    e.tag = tag; e.cnt = CNT_W'(c); e.cd = cd; e.wd = wd; e.ir = ir;
    q.push_back(e);
  endtask

  // one-cycle strobes, raised and dropped on falling edges
  task automatic fire(input logic [7:0] m, input int n = 0);
    @(negedge clk);
    tick4k = m[0]; tick64 = m[1]; tick1 = m[2]; tickMin = m[3]; tickHour = m[4];
    reloadWr = m[5]; cdFlagClr = m[6]; statusRd = m[7];
    reloadVal = CNT_W'(n);
    @(negedge clk);
    {tick4k, tick64, tick1, tickMin, tickHour, reloadWr, cdFlagClr, statusRd} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 reset", 0, 0, 0, 0);

    modeSel = 2'b01; srcSel = 3'b010;
    fire(WR, 3);   chk("R4 load", 3, 0, 0, 0);
    fire(T1);      chk("R3 dec", 2, 0, 0, 0);
    fire(T64);     chk("R2 unselected tick", 2, 0, 0, 0);
    fire(T1);      chk("R3 dec", 1, 0, 0, 0);
    fire(T1);      chk("R3 expire reload", 3, 1, 0, 0);
    @(negedge clk); cdIrqEn = 1;
    chk("R7 level irq", 3, 1, 0, 1);
    fire(CLR);     chk("R10 clear", 3, 0, 0, 0);
    fire(T1); fire(T1);
    fire(T1 | CLR); chk("R10 set wins", 3, 1, 0, 1);
    fire(CLR);

    pulseMode = 1;
    fire(T1); fire(T1); fire(T1); chk("R8 pulse start", 3, 1, 0, 1);
    fire(T4K);     chk("R8 4k does not end 1Hz pulse", 3, 1, 0, 1);
    fire(T64);     chk("R8 64Hz ends pulse", 3, 1, 0, 0);
    fire(CLR);
    fire(T1); fire(T1); fire(T1); chk("R9 pulse start", 3, 1, 0, 1);
    fire(CLR);     chk("R9 clear ends pulse", 3, 0, 0, 0);
    fire(T1); fire(T1); fire(T1); chk("R9 pulse start", 3, 1, 0, 1);
    @(negedge clk); cdIrqEn = 0;
    chk("R9 enable drop", 3, 1, 0, 0);
    @(negedge clk); cdIrqEn = 1;
    chk("R9 no resume", 3, 1, 0, 0);
    fire(CLR);

    srcSel = 3'b000;
    fire(WR, 2); fire(T4K); fire(T4K); chk("R8 4k pulse start", 2, 1, 0, 1);
    fire(T64);     chk("R8 64Hz ignored for 4k width", 2, 1, 0, 1);
    fire(T4K);     chk("R8 4k ends pulse", 1, 1, 0, 0);
    fire(CLR); pulseMode = 0;

    srcSel = 3'b011;
    fire(WR, 5);
    fire(TMIN);    chk("R2 minute tick", 4, 0, 0, 0);
    fire(THR);     chk("R2 hour ignored", 4, 0, 0, 0);
    srcSel = 3'b100; fire(THR); chk("R2 code100", 3, 0, 0, 0);
    srcSel = 3'b110; fire(THR); chk("R2 code110", 2, 0, 0, 0);
    srcSel = 3'b111; fire(THR); chk("R2 code111", 1, 0, 0, 0);
    srcSel = 3'b001; fire(T64); chk("R2 64Hz expire", 5, 1, 0, 1);
    fire(CLR);
    srcSel = 3'b000; fire(T4K); chk("R2 4k tick", 4, 0, 0, 0);
    srcSel = 3'b101;
    fire(T4K | T64); fire(T1 | TMIN); fire(THR);
    chk("R2 code101 no tick", 4, 0, 0, 0);

    srcSel = 3'b010; modeSel = 2'b00;
    fire(T1);      chk("R1 mode00 frozen", 4, 0, 0, 0);
    modeSel = 2'b11;
    fire(T1);      chk("R1 mode11 frozen", 4, 0, 0, 0);
    modeSel = 2'b01;
    fire(T1);      chk("R4 live count", 3, 0, 0, 0);
    fire(WR, 6);   chk("R4 rewrite while running", 6, 0, 0, 0);

    fire(WR, 0);   chk("R6 zero write", 0, 0, 0, 0);
    fire(T1); fire(T1); chk("R6 stays stopped", 0, 0, 0, 0);

    modeSel = 2'b10; wdIrqEn = 1;
    fire(WR, 2);
    fire(T1);      chk("R5 guard dec", 1, 0, 0, 0);
    fire(T1);      chk("R5 guard expire", 0, 0, 1, 1);
    fire(T1);      chk("R5 stays at zero", 0, 0, 1, 1);
    fire(RD);      chk("R5 read clears", 0, 0, 0, 0);

    @(negedge clk);
    done = 1;
    @(negedge clk); #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got no end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule